// File: doc/BRIEF.md
# Burst Line-Fill Streamer

This block services an instruction-cache miss. Once a miss is handed over, it reads the memory word by word. It starts at the word that missed and goes on to the last word of the cache line, with no wrap-around. Each word that comes back is written into the cache data array along with a per-word valid indication. In the same cycle, the word is offered to the instruction fetch stage. If the fetch stage stalls, memory reads go on regardless. The returned words wait in a small per-offset store and are handed out later in address order.

A redirect input signals a control transfer. It stops the fill: no new reads are issued, nothing further is forwarded, and a read already in flight still lands in the cache. The streaming mode and the cache-enable mode are sampled when a miss is accepted. With streaming off, only the missed word is read. With the cache off, words are forwarded but nothing is written into the cache. All addresses at the ports are word addresses. The line is `LINE_WORDS` words long, and the low `log2(LINE_WORDS)` address bits give the word offset within the line.

Top module: `line_fill_streamer`

## Requirements
- R1: After reset, `miss_ready` is 1 and `fetch_valid`, `mem_req_valid` and `cwr_en` are 0.
- R2: With `burst_en`=1 at acceptance, memory reads are issued for offsets from the missed offset up to `LINE_WORDS-1`, in increasing order, within the missed line, and never for a lower offset.
- R3: When the fetch stage is ready and nothing is buffered, a returned word appears on `fetch_*` in the same cycle as its `cwr_*` write, with the same address and data.
- R4: While `fetch_ready` is 0, memory reads continue until the line is fully read. An offered word stays stable until taken, and buffered words are delivered afterwards in increasing address order.
- R5: After a `redirect` cycle during a fill, no further memory read is issued and no further word is forwarded, and `miss_ready` returns to 1 once any outstanding read has returned.
- R6: With `cache_en`=0 at acceptance, words are still forwarded but `cwr_en` never rises during that fill.
- R7: A word returned with `mem_rsp_err`=1 is written with `cwr_set_valid`=0 and forwarded with `fetch_err`=1. Other words get `cwr_set_valid`=1 and `fetch_err`=0.
- R8: With `burst_en`=0 at acceptance, exactly one memory read is made, for the missed word, and exactly one word is forwarded.
- R9: A miss is accepted only while `miss_ready` is 1. `miss_ready` is 0 from the cycle after acceptance until the fill ends, and a miss presented meanwhile has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_en | input | 1 | Streaming mode, sampled at miss acceptance |
| cache_en | input | 1 | Cache write enable mode, sampled at miss acceptance |
| miss_valid | input | 1 | Miss request |
| miss_addr | input | WADDR_W | Word address that missed |
| miss_ready | output | 1 | High when no fill is in progress |
| redirect | input | 1 | Control transfer: cancel the fill |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | WADDR_W | Word address to read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DATA_W | Read data |
| mem_rsp_err | input | 1 | Read returned an error |
| fetch_valid | output | 1 | Word offered to fetch stage |
| fetch_ready | input | 1 | Fetch stage takes the word |
| fetch_addr | output | WADDR_W | Word address of offered word |
| fetch_data | output | DATA_W | Offered word |
| fetch_err | output | 1 | Offered word carried a memory error |
| cwr_en | output | 1 | Cache data array write |
| cwr_addr | output | WADDR_W | Word address written |
| cwr_data | output | DATA_W | Data written |
| cwr_set_valid | output | 1 | Set the sub-block valid bit for this word |

## Verification
The hardest condition to reach from the ports is a redirect that arrives while a read is still outstanding and some words are already forwarded. The bench sets its memory model to a two-cycle latency and counts forwarded words. It pulses `redirect` right after the second word is taken, then checks that the forward count stays frozen, that at most one extra read was issued, and that a new miss is accepted afterwards. The stall backlog is reached by holding `fetch_ready` low across a whole line, so that all reads finish before any word drains.

// File: rtl/lfs_pkg.sv
// Package: shared types of the line-fill streamer.
// Assumes nothing beyond IEEE 1800-2017.
package lfs_pkg;
    typedef enum logic [1:0] {
        FILL_IDLE   = 2'd0,
        FILL_ISSUE  = 2'd1,
        FILL_WAIT   = 2'd2,
        FILL_FINISH = 2'd3
    } fill_state_e;
endpackage

// File: rtl/lfs_req_seq.sv
// Module: lfs_req_seq
// Issues one memory read at a time for word offsets first..last of a line.
// Tracks the cancel caused by a redirect and tells the top when the fill ends.
// Assumes: LINE_WORDS is a power of two, last_off_i >= first_off_i at start,
// and at most one read response per issued request.
module lfs_req_seq
    import lfs_pkg::*;
#(
    parameter int WADDR_W    = 30,
    parameter int LINE_WORDS = 8,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int BASE_W    = WADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [BASE_W-1:0]  start_base_i,
    input  logic [OFF_W-1:0]   first_off_i,
    input  logic [OFF_W-1:0]   last_off_i,
    input  logic               redirect_i,
    input  logic               drain_done_i,
    input  logic               mem_req_ready_i,
    input  logic               mem_rsp_valid_i,
    output logic               busy_o,
    output logic               rsp_expect_o,
    output logic               cancel_o,
    output logic               mem_req_valid_o,
    output logic [WADDR_W-1:0] mem_req_addr_o,
    output logic [OFF_W-1:0]   rsp_off_o,
    output logic [BASE_W-1:0]  base_o
);
    fill_state_e        state;
    logic [OFF_W-1:0]   req_off;
    logic [OFF_W-1:0]   last_q;
    logic [BASE_W-1:0]  base_q;
    logic               cancel_q;

    // Fill sequencing: issue, wait for data, step offset, finish or cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FILL_IDLE;
            req_off  <= '0;
            last_q   <= '0;
            base_q   <= '0;
            cancel_q <= 1'b0;
        end else begin
            case (state)
                FILL_IDLE: if (start_i) begin
                    state    <= FILL_ISSUE;
                    req_off  <= first_off_i;
                    last_q   <= last_off_i;
                    base_q   <= start_base_i;
                    cancel_q <= 1'b0;
                end
                FILL_ISSUE: begin
                    if (redirect_i) begin
                        cancel_q <= 1'b1;
                        state    <= FILL_FINISH;
                    end else if (mem_req_ready_i) begin
                        state <= FILL_WAIT;
                    end
                end
                FILL_WAIT: begin
                    if (redirect_i) cancel_q <= 1'b1;
                    if (mem_rsp_valid_i) begin
                        if (cancel_q || redirect_i || req_off == last_q) begin
                            state <= FILL_FINISH;
                        end else begin
                            req_off <= req_off + 1'b1;
                            state   <= FILL_ISSUE;
                        end
                    end
                end
                default: begin
                    if (cancel_q || drain_done_i) begin
                        state    <= FILL_IDLE;
                        cancel_q <= 1'b0;
                    end else if (redirect_i) begin
                        cancel_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    // Port views of the sequencer state.
    always_comb begin
        busy_o          = (state != FILL_IDLE);
        rsp_expect_o    = (state == FILL_WAIT);
        cancel_o        = cancel_q;
        mem_req_valid_o = (state == FILL_ISSUE) && !redirect_i;
        mem_req_addr_o  = {base_q, req_off};
        rsp_off_o       = req_off;
        base_o          = base_q;
    end

    // R5
    redirect_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_i && state != FILL_IDLE) |=> !mem_req_valid_o);

    // R2
    line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (req_off <= last_q));
endmodule

// File: rtl/lfs_stream_buf.sv
// Module: lfs_stream_buf
// Per-offset holding store between memory responses and the fetch stage.
// A word goes straight through when it is the next one due and the fetch
// stage is ready. Otherwise it is parked in the slot for its offset.
// Slots drain from the head offset upward.
// Assumes: words arrive in increasing offset order, each offset once per fill.
module lfs_stream_buf #(
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int OFF_W     = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OFF_W-1:0]  first_off_i,
    input  logic [OFF_W-1:0]  last_off_i,
    input  logic              kill_i,
    input  logic              wr_valid_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wr_err_i,
    input  logic              out_ready_i,
    output logic              out_valid_o,
    output logic [OFF_W-1:0]  out_off_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic              out_err_o,
    output logic              done_o
);
    logic [LINE_WORDS-1:0] slot_vld;
    logic [LINE_WORDS-1:0] slot_err;
    logic [DATA_W-1:0]     slot_data [LINE_WORDS];
    logic [OFF_W-1:0]      head;
    logic [OFF_W-1:0]      last_q;
    logic                  done_q;
    logic                  head_hit;
    logic                  bypass_ok;
    logic                  push;
    logic                  take;

    // Offer selection: parked head word first, else a passing response.
    always_comb begin
        head_hit    = slot_vld[head];
        bypass_ok   = !head_hit && wr_valid_i && (wr_off_i == head);
        out_valid_o = !kill_i && !done_q && (head_hit || bypass_ok);
        out_off_o   = head;
        out_data_o  = head_hit ? slot_data[head] : wr_data_i;
        out_err_o   = head_hit ? slot_err[head]  : wr_err_i;
        take        = out_valid_o && out_ready_i;
        push        = wr_valid_i && !kill_i && !(bypass_ok && out_ready_i);
        done_o      = done_q;
    end

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_slot
        // Slot occupancy: set on park, cleared on drain, start or kill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[g] <= 1'b0;
            end else if (start_i || kill_i) begin
                slot_vld[g] <= 1'b0;
            end else if (push && wr_off_i == OFF_W'(g)) begin
                slot_vld[g] <= 1'b1;
            end else if (take && head_hit && head == OFF_W'(g)) begin
                slot_vld[g] <= 1'b0;
            end
        end

        // Slot payload capture on park.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_data[g] <= '0;
                slot_err[g]  <= 1'b0;
            end else if (push && wr_off_i == OFF_W'(g)) begin
                slot_data[g] <= wr_data_i;
                slot_err[g]  <= wr_err_i;
            end
        end
    end

    // Head pointer and end-of-delivery flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head   <= '0;
            last_q <= '0;
            done_q <= 1'b1;
        end else if (start_i) begin
            head   <= first_off_i;
            last_q <= last_off_i;
            done_q <= 1'b0;
        end else if (kill_i) begin
            done_q <= 1'b1;
        end else if (take) begin
            if (head == last_q) done_q <= 1'b1;
            else                head   <= head + 1'b1;
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !slot_vld[wr_off_i]);
endmodule

// File: rtl/line_fill_streamer.sv
// Module: line_fill_streamer (top)
// Accepts an instruction miss when idle and reads the line from the missed
// word to the line end. It writes each word into the cache data array and
// streams it to the fetch stage. Modes are sampled at acceptance.
// Assumes: word-granular addresses, one outstanding memory read,
// mem_rsp_valid only while a read is outstanding.
module line_fill_streamer #(
    parameter int WADDR_W    = 30,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int BASE_W    = WADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               burst_en,
    input  logic               cache_en,
    input  logic               miss_valid,
    input  logic [WADDR_W-1:0] miss_addr,
    output logic               miss_ready,
    input  logic               redirect,
    output logic               mem_req_valid,
    output logic [WADDR_W-1:0] mem_req_addr,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [DATA_W-1:0]  mem_rsp_data,
    input  logic               mem_rsp_err,
    output logic               fetch_valid,
    input  logic               fetch_ready,
    output logic [WADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0]  fetch_data,
    output logic               fetch_err,
    output logic               cwr_en,
    output logic [WADDR_W-1:0] cwr_addr,
    output logic [DATA_W-1:0]  cwr_data,
    output logic               cwr_set_valid
);
    logic              busy;
    logic              rsp_expect;
    logic              cancel;
    logic              start;
    logic              rsp_take;
    logic              kill;
    logic              drain_done;
    logic              fill_cache_q;
    logic [OFF_W-1:0]  first_off;
    logic [OFF_W-1:0]  last_off;
    logic [OFF_W-1:0]  rsp_off;
    logic [OFF_W-1:0]  out_off;
    logic [BASE_W-1:0] base;

    // Acceptance, line window and response qualification.
    always_comb begin
        miss_ready    = !busy;
        start         = miss_valid && !busy;
        first_off     = miss_addr[OFF_W-1:0];
        last_off      = burst_en ? OFF_W'(LINE_WORDS - 1) : first_off;
        rsp_take      = mem_rsp_valid && rsp_expect;
        kill          = busy && (redirect || cancel);
        cwr_en        = rsp_take && fill_cache_q;
        cwr_addr      = {base, rsp_off};
        cwr_data      = mem_rsp_data;
        cwr_set_valid = !mem_rsp_err;
        fetch_addr    = {base, out_off};
    end

    // Cache-write mode captured with each accepted miss.
    always_ff @(posedge clk) begin
        if (!rst_n)     fill_cache_q <= 1'b0;
        else if (start) fill_cache_q <= cache_en;
    end

    lfs_req_seq #(
        .WADDR_W    (WADDR_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start),
        .start_base_i    (miss_addr[WADDR_W-1:OFF_W]),
        .first_off_i     (first_off),
        .last_off_i      (last_off),
        .redirect_i      (redirect),
        .drain_done_i    (drain_done),
        .mem_req_ready_i (mem_req_ready),
        .mem_rsp_valid_i (mem_rsp_valid),
        .busy_o          (busy),
        .rsp_expect_o    (rsp_expect),
        .cancel_o        (cancel),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_addr_o  (mem_req_addr),
        .rsp_off_o       (rsp_off),
        .base_o          (base)
    );

    lfs_stream_buf #(
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .first_off_i (first_off),
        .last_off_i  (last_off),
        .kill_i      (kill),
        .wr_valid_i  (rsp_take),
        .wr_off_i    (rsp_off),
        .wr_data_i   (mem_rsp_data),
        .wr_err_i    (mem_rsp_err),
        .out_ready_i (fetch_ready),
        .out_valid_o (fetch_valid),
        .out_off_o   (out_off),
        .out_data_o  (fetch_data),
        .out_err_o   (fetch_err),
        .done_o      (drain_done)
    );

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> !miss_ready);

    // R4
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_ready && !redirect) |=>
            (fetch_valid && $stable(fetch_addr) && $stable(fetch_data)));
endmodule

// File: tb/line_fill_streamer_test.sv
module line_fill_streamer_test;
    localparam int AW = 30;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          burst_en = 1'b1, cache_en = 1'b1;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          miss_ready;
    logic          redirect = 1'b0;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b1;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          mem_rsp_err = 1'b0;
    logic          fetch_valid;
    logic          fetch_ready = 1'b1;
    logic [AW-1:0] fetch_addr;
    logic [DW-1:0] fetch_data;
    logic          fetch_err;
    logic          cwr_en;
    logic [AW-1:0] cwr_addr;
    logic [DW-1:0] cwr_data;
    logic          cwr_set_valid;

    int vectors = 0, fails = 0;
    int lat = 1;
    logic [AW-1:0] err_addr = '1;

    int            fw_n, cw_n, rq_n, same_bad, busy_seen;
    logic [AW-1:0] fw_a [16];
    logic [DW-1:0] fw_d [16];
    logic          fw_e [16];
    logic [AW-1:0] cw_a [16];
    logic          cw_v [16];
    logic [AW-1:0] rq_a [16];

    always #10 clk = ~clk;

    line_fill_streamer uut (.*);

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        fw_n = 0; cw_n = 0; rq_n = 0; same_bad = 0; busy_seen = 0;
    endtask

    // Memory model: one read at a time, response after lat extra cycles.
    initial begin
        bit pend = 0;
        int cd = 0;
        logic [AW-1:0] a = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cd == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(a);
                    mem_rsp_err   = (a == err_addr);
                    pend = 0;
                end else cd--;
            end
            #8;
            if (mem_req_valid && mem_req_ready) begin
                pend = 1; cd = lat; a = mem_req_addr;
                if (rq_n < 16) rq_a[rq_n] = a;
                rq_n++;
            end
        end
    end

    // Monitor: log transfers and cache writes just before each rising edge.
    initial begin
        forever begin
            @(negedge clk); #8;
            if (!miss_ready) busy_seen++;
            if (fetch_valid && fetch_ready) begin
                if (fw_n < 16) begin
                    fw_a[fw_n] = fetch_addr; fw_d[fw_n] = fetch_data; fw_e[fw_n] = fetch_err;
                end
                fw_n++;
            end
            if (cwr_en) begin
                if (cw_n < 16) begin cw_a[cw_n] = cwr_addr; cw_v[cw_n] = cwr_set_valid; end
                cw_n++;
                if (!(fetch_valid && fetch_ready && fetch_addr == cwr_addr && fetch_data == cwr_data))
                    same_bad++;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    task automatic issue_miss(input logic [AW-1:0] a, input logic b, input logic c);
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = a; burst_en = b; cache_en = c;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); #8;
            if (miss_ready) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_stream(input string tag, input logic [AW-1:0] first, input int n);
        int bad = 0;
        for (int i = 0; i < n && i < 16; i++)
            if (fw_a[i] != first + AW'(i) || fw_d[i] != mem_word(first + AW'(i))) bad++;
        chk(bad == 0, tag, "forwarded words in address order", bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk); #8;
        chk(miss_ready == 1'b1, "R1", "miss_ready", miss_ready, 1);
        chk(fetch_valid == 1'b0, "R1", "fetch_valid", fetch_valid, 0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
        chk(cwr_en == 1'b0, "R1", "cwr_en", cwr_en, 0);
    endtask

    task automatic t_burst_mid();
        logic [AW-1:0] a = 30'h0000_1233;
        int bad = 0;
        clear_logs(); lat = 1;
        issue_miss(a, 1'b1, 1'b1);
        wait_idle();
        chk(rq_n == 5, "R2", "reads from offset 3", rq_n, 5);
        for (int i = 0; i < 5; i++) if (rq_a[i] != a + AW'(i)) bad++;
        chk(bad == 0, "R2", "read addresses ascending", bad, 0);
        chk(fw_n == 5, "R3", "words forwarded", fw_n, 5);
        check_stream("R3", a, 5);
        chk(cw_n == 5, "R3", "cache writes", cw_n, 5);
        chk(same_bad == 0, "R3", "write and forward in same cycle", same_bad, 0);
    endtask

    task automatic t_burst_edges();
        clear_logs(); lat = 0;
        issue_miss(30'h0000_4440, 1'b1, 1'b1);
        wait_idle();
        chk(rq_n == 8 && fw_n == 8, "R2", "full line from offset 0", fw_n, 8);
        check_stream("R2", 30'h0000_4440, 8);
        chk(same_bad == 0, "R3", "same-cycle forward at zero latency", same_bad, 0);
        clear_logs();
        issue_miss(30'h0000_4447, 1'b1, 1'b1);
        wait_idle();
        chk(rq_n == 1 && fw_n == 1, "R2", "last offset gives one word", fw_n, 1);
        chk(fw_a[0] == 30'h0000_4447, "R2", "last offset address", fw_a[0], 30'h0000_4447);
    endtask

    task automatic t_single();
        clear_logs(); lat = 2;
        issue_miss(30'h0000_2225, 1'b0, 1'b1);
        wait_idle();
        chk(rq_n == 1, "R8", "reads with streaming off", rq_n, 1);
        chk(fw_n == 1 && fw_a[0] == 30'h0000_2225, "R8", "single word forwarded", fw_n, 1);
        chk(cw_n == 1, "R8", "single cache write", cw_n, 1);
    endtask

    task automatic t_nocache();
        clear_logs(); lat = 1;
        issue_miss(30'h0000_3332, 1'b1, 1'b0);
        wait_idle();
        chk(fw_n == 6, "R6", "words forwarded with cache off", fw_n, 6);
        check_stream("R6", 30'h0000_3332, 6);
        chk(cw_n == 0, "R6", "no cache writes", cw_n, 0);
    endtask

    task automatic t_error();
        int bad = 0;
        clear_logs(); lat = 1; err_addr = 30'h0000_5554;
        issue_miss(30'h0000_5551, 1'b1, 1'b1);
        wait_idle();
        chk(cw_n == 7, "R7", "writes incl. failed word", cw_n, 7);
        for (int i = 0; i < 7; i++) begin
            if (cw_v[i] != (cw_a[i] != err_addr)) bad++;
            if (fw_e[i] != (fw_a[i] == err_addr)) bad++;
        end
        chk(bad == 0, "R7", "valid and error flags per word", bad, 0);
        chk(cw_v[3] == 1'b0, "R7", "failed word not valid", cw_v[3], 0);
        err_addr = '1;
    endtask

    task automatic t_stall();
        clear_logs(); lat = 1;
        @(negedge clk); fetch_ready = 1'b0;
        issue_miss(30'h0000_6660, 1'b1, 1'b1);
        repeat (40) @(negedge clk);
        chk(rq_n == 8, "R4", "reads continue during stall", rq_n, 8);
        chk(fw_n == 0, "R4", "nothing taken during stall", fw_n, 0);
        chk(miss_ready == 1'b0, "R4", "fill held until drained", miss_ready, 0);
        fetch_ready = 1'b1;
        wait_idle();
        chk(fw_n == 8, "R4", "buffered words drained", fw_n, 8);
        check_stream("R4", 30'h0000_6660, 8);
    endtask

    task automatic t_redirect();
        int at;
        clear_logs(); lat = 2;
        issue_miss(30'h0000_7770, 1'b1, 1'b1);
        for (int i = 0; i < 200 && fw_n < 2; i++) @(negedge clk);
        at = fw_n;
        redirect = 1'b1;
        @(negedge clk);
        redirect = 1'b0;
        wait_idle();
        chk(fw_n == at, "R5", "no forwarding after redirect", fw_n, at);
        chk(rq_n <= at + 1, "R5", "reads stop after redirect", rq_n, at + 1);
        chk(miss_ready == 1'b1, "R5", "idle after redirect", miss_ready, 1);
        clear_logs(); lat = 0;
        issue_miss(30'h0000_7776, 1'b1, 1'b1);
        wait_idle();
        chk(fw_n == 2, "R5", "next miss after redirect", fw_n, 2);
        check_stream("R5", 30'h0000_7776, 2);
    endtask

    task automatic t_busy_miss();
        clear_logs(); lat = 1;
        @(negedge clk); fetch_ready = 1'b0;
        issue_miss(30'h0000_8884, 1'b1, 1'b1);
        miss_valid = 1'b1; miss_addr = 30'h0000_9990;
        repeat (4) @(negedge clk);
        #8;
        chk(miss_ready == 1'b0, "R9", "miss_ready low during fill", miss_ready, 0);
        @(negedge clk);
        miss_valid = 1'b0;
        fetch_ready = 1'b1;
        wait_idle();
        chk(rq_n == 4, "R9", "second miss ignored, reads", rq_n, 4);
        chk(fw_n == 4, "R9", "second miss ignored, words", fw_n, 4);
        check_stream("R9", 30'h0000_8884, 4);
    endtask

    initial begin
        clear_logs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_burst_mid();
        t_burst_edges();
        t_single();
        t_nocache();
        t_error();
        t_stall();
        t_redirect();
        t_busy_miss();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule